// File: doc/BRIEF.md
# Background Debug Activation Controller

This block decides when a microcontroller core enters and leaves active background debug mode. It keeps two separate conditions. One is an enable flag that the debug interface writes with a byte-write command. The other is the active state, in which the debug register and ROM window is mapped and the core is held halted. Debug firmware can only run when both conditions hold.

Three sources can request activation: a host "background" command, an instruction-tag hit, and the core's software background instruction. Each source takes effect at its own point relative to an instruction. A request made while the enable flag is clear is dropped: the core is held for a short fixed number of cycles and then released, and the active output never rises. While active, the block decodes the top 256-byte page of the address space as the debug window. It marks the low register slots as reachable only by debug-logic accesses. It also drives a per-peripheral freeze output so that suspendable peripherals, such as a timer counter, stop counting. A go/exit pulse from the firmware returns the core to normal execution.

When reset is released in special single-chip mode, the block starts up enabled and active, so a part with blank memory can be programmed. All pins are plain control and status signals; there is no streamed data path, so no valid/ready handshake applies.

Top module: `bdm_activation_ctrl`

## Requirements
- R1: During and after reset, with `special_mode_i` low, `enabled_o`, `active_o` and `halt_o` are 0. With `special_mode_i` high, all three are 1.
- R2: A pulse on `cfg_wr_i` with `cfg_addr_i` equal to 8'h01 loads `enabled_o` from bit 7 of `cfg_wdata_i`, visible in the next cycle. A write to any other offset leaves `enabled_o` unchanged.
- R3: `active_o` only rises in a cycle following one in which `enabled_o` was 1.
- R4: A request from any source while disabled and running raises `resuming_o` and `halt_o` for exactly DROP_CYCLES (default 16) cycles, starting the cycle after the request. During that time `active_o` stays 0, and afterwards the core runs again.
- R5: A tag hit or a background instruction while enabled and running makes `active_o` and `halt_o` 1 in the next cycle, without waiting for an instruction boundary.
- R6: A host background command while enabled is held until `insn_boundary_i` is high. This may be in the same cycle as the command or a later one. `active_o` rises the cycle after that boundary.
- R7: `win_hit_o` is 1 exactly when `active_o` is 1 and `bus_addr_i[15:8]` is 8'hFF.
- R8: `reg_hit_o` is 1 exactly when `win_hit_o` is 1, `bus_addr_i[7:0]` is at most 8'h06, and `dbg_access_i` is 1. A user access (`dbg_access_i` low) never selects the registers.
- R9: A `go_i` pulse while active clears `active_o` and `halt_o` in the next cycle.
- R10: Each bit of `freeze_o` equals the matching bit of `suspend_en_i` ANDed with `active_o`.
- R11: Activation requests that arrive while active or resuming are ignored. They change neither the state nor the length of the resume hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode_i | input | 1 | Special single-chip mode strap, sampled in reset |
| cfg_wr_i | input | 1 | Hardware byte-write strobe from the debug interface |
| cfg_addr_i | input | 8 | Offset of the byte write within the debug page |
| cfg_wdata_i | input | 8 | Byte-write data; bit 7 at offset 8'h01 is the enable |
| host_bgnd_i | input | 1 | Host background command pulse |
| insn_boundary_i | input | 1 | Core is at an instruction boundary |
| tag_hit_i | input | 1 | Tagged instruction is about to execute |
| bgnd_insn_i | input | 1 | Core executed its background instruction |
| go_i | input | 1 | Exit pulse from debug firmware |
| bus_addr_i | input | 16 | Current bus address |
| dbg_access_i | input | 1 | Current access is made by debug logic |
| suspend_en_i | input | NUM_PERIPH | Per-peripheral debug-suspend control bits |
| enabled_o | output | 1 | Enable flag |
| active_o | output | 1 | Active background mode |
| halt_o | output | 1 | Halt request to the core |
| resuming_o | output | 1 | Dropped-request hold in progress |
| win_hit_o | output | 1 | Address falls in the mapped debug window |
| reg_hit_o | output | 1 | Address selects a debug control register |
| freeze_o | output | NUM_PERIPH | Peripheral freeze lines |

## Verification
The bench sends a host command with no boundary for several cycles and then supplies one. A design that activated at once, or forgot the pending command, would show `active_o` too early or never. It fires requests while disabled and counts the halt cycles. A counter off by one, or a hold that also raised `active_o`, would show up in that count. It also fires new requests during the resume hold and while active; a design that restarted the hold or re-entered the state would change the timing. It walks addresses across the edge of the register block and the window, with debug and user accesses. A decoder with a wrong bound or a missing access check would select registers for user code.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_ACTIVE = 2'd1,
    MODE_RESUME = 2'd2
  } dbg_mode_e;

  localparam logic [7:0] STATUS_OFFSET = 8'h01;
  localparam int         ENABLE_BIT    = 7;
endpackage

// File: rtl/bdm_req_arbiter.sv
module bdm_req_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_i,
  input  logic enabled_i,
  input  logic host_bgnd_i,
  input  logic insn_boundary_i,
  input  logic tag_hit_i,
  input  logic bgnd_insn_i,
  output logic act_o,
  output logic drop_o
);
  logic pend_q, pend_d;
  logic host_any, immediate, any_req;

  assign host_any  = host_bgnd_i | pend_q;
  assign immediate = tag_hit_i | bgnd_insn_i;
  assign any_req   = immediate | host_bgnd_i;

  // tags and the background instruction act at once; host waits for a boundary
  assign act_o  = idle_i & enabled_i & (immediate | (host_any & insn_boundary_i));
  assign drop_o = idle_i & ~enabled_i & any_req;

  assign pend_d = idle_i & enabled_i & ~act_o & host_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/bdm_mode_fsm.sv
module bdm_mode_fsm
  import bdm_pkg::*;
#(
  parameter int DROP_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       special_mode_i,
  input  logic       cfg_wr_i,
  input  logic [7:0] cfg_addr_i,
  input  logic [7:0] cfg_wdata_i,
  input  logic       act_i,
  input  logic       drop_i,
  input  logic       go_i,
  output dbg_mode_e  mode_o,
  output logic       enabled_o
);
  localparam int CNT_W = $clog2(DROP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DROP_CYCLES - 1);

  dbg_mode_e      mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic           en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (cfg_wr_i && cfg_addr_i == STATUS_OFFSET) en_d = cfg_wdata_i[ENABLE_BIT];
  end

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (act_i) mode_d = MODE_ACTIVE;
        else if (drop_i) begin
          mode_d = MODE_RESUME;
          cnt_d  = CNT_LOAD;
        end
      end
      MODE_ACTIVE: if (go_i) mode_d = MODE_RUN;
      MODE_RESUME: begin
        if (cnt_q == '0) mode_d = MODE_RUN;
        else             cnt_d  = cnt_q - 1'b1;
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= special_mode_i ? MODE_ACTIVE : MODE_RUN;
      en_q   <= special_mode_i;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      en_q   <= en_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode_o    = mode_q;
  assign enabled_o = en_q;
endmodule

// File: rtl/bdm_window_decode.sv
module bdm_window_decode #(
  parameter int ADDR_W    = 16,
  parameter int REG_COUNT = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              active_i,
  input  logic              dbg_access_i,
  output logic              win_hit_o,
  output logic              reg_hit_o
);
  localparam int PAGE_W = ADDR_W - 8;
  localparam logic [PAGE_W-1:0] PAGE_TOP = '1;
  localparam logic [7:0] REG_LAST = 8'(REG_COUNT - 1);

  assign win_hit_o = active_i && (addr_i[ADDR_W-1:8] == PAGE_TOP);
  assign reg_hit_o = win_hit_o && dbg_access_i && (addr_i[7:0] <= REG_LAST);
endmodule

// File: rtl/bdm_freeze.sv
module bdm_freeze #(
  parameter int NUM_PERIPH = 4
) (
  input  logic                  active_i,
  input  logic [NUM_PERIPH-1:0] suspend_en_i,
  output logic [NUM_PERIPH-1:0] freeze_o
);
  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_lane
    assign freeze_o[g] = active_i & suspend_en_i[g];
  end
endmodule

// File: rtl/bdm_activation_ctrl.sv
module bdm_activation_ctrl
  import bdm_pkg::*;
#(
  parameter int DROP_CYCLES = 16,
  parameter int ADDR_W      = 16,
  parameter int REG_COUNT   = 7,
  parameter int NUM_PERIPH  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  special_mode_i,
  input  logic                  cfg_wr_i,
  input  logic [7:0]            cfg_addr_i,
  input  logic [7:0]            cfg_wdata_i,
  input  logic                  host_bgnd_i,
  input  logic                  insn_boundary_i,
  input  logic                  tag_hit_i,
  input  logic                  bgnd_insn_i,
  input  logic                  go_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic                  dbg_access_i,
  input  logic [NUM_PERIPH-1:0] suspend_en_i,
  output logic                  enabled_o,
  output logic                  active_o,
  output logic                  halt_o,
  output logic                  resuming_o,
  output logic                  win_hit_o,
  output logic                  reg_hit_o,
  output logic [NUM_PERIPH-1:0] freeze_o
);
  dbg_mode_e mode;
  logic act, drop, idle;

  assign idle = (mode == MODE_RUN);

  bdm_req_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .idle_i(idle), .enabled_i(enabled_o),
    .host_bgnd_i(host_bgnd_i), .insn_boundary_i(insn_boundary_i),
    .tag_hit_i(tag_hit_i), .bgnd_insn_i(bgnd_insn_i),
    .act_o(act), .drop_o(drop)
  );

  bdm_mode_fsm #(.DROP_CYCLES(DROP_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .special_mode_i(special_mode_i),
    .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .act_i(act), .drop_i(drop), .go_i(go_i),
    .mode_o(mode), .enabled_o(enabled_o)
  );

  assign active_o   = (mode == MODE_ACTIVE);
  assign resuming_o = (mode == MODE_RESUME);
  assign halt_o     = active_o | resuming_o;

  bdm_window_decode #(.ADDR_W(ADDR_W), .REG_COUNT(REG_COUNT)) u_win (
    .addr_i(bus_addr_i), .active_i(active_o), .dbg_access_i(dbg_access_i),
    .win_hit_o(win_hit_o), .reg_hit_o(reg_hit_o)
  );

  bdm_freeze #(.NUM_PERIPH(NUM_PERIPH)) u_frz (
    .active_i(active_o), .suspend_en_i(suspend_en_i), .freeze_o(freeze_o)
  );
endmodule

// File: rtl/bdm_activation_chk.sv
module bdm_activation_chk #(
  parameter int NUM_PERIPH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tag_hit_i,
  input logic                  bgnd_insn_i,
  input logic                  go_i,
  input logic                  dbg_access_i,
  input logic                  enabled_o,
  input logic                  active_o,
  input logic                  halt_o,
  input logic                  resuming_o,
  input logic                  win_hit_o,
  input logic                  reg_hit_o,
  input logic [NUM_PERIPH-1:0] freeze_o
);
  AST_ACT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(enabled_o)); // R3
  AST_RESUME_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    resuming_o |-> (halt_o && !active_o)); // R4
  AST_FAST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((tag_hit_i || bgnd_insn_i) && enabled_o && !halt_o) |=> active_o); // R5
  AST_WIN_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit_o |-> active_o); // R7
  AST_REG_DEBUG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hit_o |-> (win_hit_o && dbg_access_i)); // R8
  AST_GO_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && go_i) |=> (!active_o && !halt_o)); // R9
  AST_FREEZE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_o != '0) |-> active_o); // R10
  AST_RESUME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (resuming_o && (tag_hit_i || bgnd_insn_i)) |=> !active_o); // R11
endmodule

bind bdm_activation_ctrl bdm_activation_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tag_hit_i(tag_hit_i), .bgnd_insn_i(bgnd_insn_i),
  .go_i(go_i), .dbg_access_i(dbg_access_i), .enabled_o(enabled_o),
  .active_o(active_o), .halt_o(halt_o), .resuming_o(resuming_o),
  .win_hit_o(win_hit_o), .reg_hit_o(reg_hit_o), .freeze_o(freeze_o)
);

// File: tb/bdm_activation_ctrl_test.sv
`timescale 1ns/100ps
module bdm_activation_ctrl_test;
  localparam int DROP = 16;
  localparam int NP   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic special = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_addr = 8'h00, cfg_wdata = 8'h00;
  logic host = 1'b0, bnd = 1'b0, tag = 1'b0, bi = 1'b0, go = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic dbg = 1'b0;
  logic [NP-1:0] susp = '0;
  logic en_o, act_o, halt_o, res_o, win_o, reg_o;
  logic [NP-1:0] frz_o;

  always #2.5 clk = ~clk;

  bdm_activation_ctrl #(.DROP_CYCLES(DROP), .NUM_PERIPH(NP)) uut (
    .clk(clk), .rst_n(rst_n), .special_mode_i(special),
    .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .host_bgnd_i(host), .insn_boundary_i(bnd), .tag_hit_i(tag),
    .bgnd_insn_i(bi), .go_i(go), .bus_addr_i(addr), .dbg_access_i(dbg),
    .suspend_en_i(susp), .enabled_o(en_o), .active_o(act_o), .halt_o(halt_o),
    .resuming_o(res_o), .win_hit_o(win_o), .reg_hit_o(reg_o), .freeze_o(frz_o)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, got, exp, $time);
    end
  endtask

  // behavioural reference: mode 0 run, 1 active, 2 resuming
  int m_mode = 0, m_cnt = 0;
  bit m_en = 0, m_pend = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = special; m_mode = special ? 1 : 0; m_pend = 0; m_cnt = 0;
    end else begin
      bit nen;
      nen = (cfg_wr && cfg_addr == 8'h01) ? cfg_wdata[7] : m_en;
      if (m_mode == 0) begin
        if (m_en) begin
          if (tag || bi || ((host || m_pend) && bnd)) begin m_mode = 1; m_pend = 0; end
          else m_pend = m_pend || host;
        end else begin
          m_pend = 0;
          if (tag || bi || host) begin m_mode = 2; m_cnt = DROP - 1; end
        end
      end else if (m_mode == 1) begin
        if (go) m_mode = 0;
      end else begin
        if (m_cnt == 0) m_mode = 0; else m_cnt--;
      end
      m_en = nen;
    end
    #1;
    begin
      bit ea, ew;
      ea = (m_mode == 1);
      ew = ea && addr[15:8] == 8'hFF;
      chk("R1/R2 enabled", en_o, m_en);
      chk("R3/R5/R6/R9/R11 active", act_o, ea);
      chk("R4 halt", halt_o, m_mode != 0);
      chk("R4 resuming", res_o, m_mode == 2);
      chk("R7 window", win_o, ew);
      chk("R8 regs", reg_o, ew && dbg && addr[7:0] <= 8'h06);
      chk("R10 freeze", frz_o, ea ? susp : '0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tag();  tag = 1; cyc(1); tag = 0; endtask
  task automatic pulse_go();   go = 1;  cyc(1); go = 0;  endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d; cyc(1); cfg_wr = 0;
  endtask

  initial begin
    cyc(3);
    chk("R1 reset disabled", {en_o, act_o, halt_o}, 3'b000);
    rst_n = 1; cyc(2);
    chk("R1 after reset", {en_o, act_o, halt_o}, 3'b000);

    // dropped request while disabled
    begin
      int hc = 0;
      cyc(0);
      tag = 1; cyc(1); tag = 0;
      for (int i = 0; i < 40; i++) begin
        if (halt_o) hc++;
        if (i == 3) begin bi = 1; end
        if (i == 4) begin bi = 0; end
        chk("R4 never active while dropped", act_o, 0);
        cyc(1);
      end
      chk("R4/R11 hold length", hc, DROP);
    end

    wr(8'h02, 8'h80); cyc(1);
    chk("R2 other offset ignored", en_o, 0);
    wr(8'h01, 8'h80); // write at negedge; effective next edge
    chk("R2 enable set", en_o, 1);

    susp = 4'b1010;
    pulse_tag();
    chk("R5 tag activates", {act_o, halt_o}, 2'b11);
    chk("R10 freeze lanes", frz_o, 4'b1010);
    dbg = 1; addr = 16'hFF06; cyc(1);
    chk("R8 last reg", reg_o, 1);
    addr = 16'hFF07; cyc(1);
    chk("R8 past regs", {win_o, reg_o}, 2'b10);
    addr = 16'hFF00; dbg = 0; cyc(1);
    chk("R8 user blocked", {win_o, reg_o}, 2'b10);
    addr = 16'hFE00; dbg = 1; cyc(1);
    chk("R7 outside window", win_o, 0);
    host = 1; bnd = 1; cyc(1); host = 0; bnd = 0; cyc(1);
    chk("R11 request while active", act_o, 1);
    pulse_go();
    chk("R9 exit", {act_o, halt_o}, 2'b00);
    addr = 16'hFF01; cyc(1);
    chk("R7 no window when idle", {win_o, reg_o, frz_o}, 6'b0);

    host = 1; cyc(1); host = 0; cyc(3);
    chk("R6 waits for boundary", act_o, 0);
    bnd = 1; cyc(1); bnd = 0;
    chk("R6 boundary activates", act_o, 1);
    pulse_go();

    host = 1; bnd = 1; cyc(1); host = 0; bnd = 0;
    chk("R6 same-cycle boundary", act_o, 1);
    pulse_go();

    bi = 1; cyc(1); bi = 0;
    chk("R5 background instruction", act_o, 1);
    wr(8'h01, 8'h00);
    chk("R2 clear enable", {en_o, act_o}, 2'b01);
    pulse_go();
    host = 1; bnd = 1; cyc(1); host = 0; bnd = 0;
    chk("R3/R4 disabled host drops", {act_o, res_o}, 2'b01);
    cyc(DROP + 2);
    chk("R4 resumes", halt_o, 0);

    rst_n = 0; special = 1; cyc(2);
    rst_n = 1; cyc(2);
    chk("R1 special mode", {en_o, act_o, halt_o}, 3'b111);
    pulse_go();
    chk("R9 leave special", act_o, 0);
    pulse_tag();
    chk("R5 re-enter", act_o, 1);
    cyc(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule